// File: doc/BRIEF.md
# Signed Booth-Recoded Tree Multiplier

This block multiplies two 16-bit two's-complement operands and returns the full 32-bit signed product one clock after the operands are presented. It has no iteration and no multi-cycle schedule. The whole product is formed combinationally between the input and a single output register. The multiplier operand is recoded, two bits at a time, into eight radix-4 signed digits. Each digit picks zero, one or two times the multiplicand, with or without negation. This gives eight shifted partial products.

A negated multiple is the bit-inverse of the selected multiple. The missing +1 of each such negation is gathered into one extra correction row. The eight partial-product rows and the correction row pass through levels of 3:2 carry-save compressors until two rows remain. One carry-propagate addition then produces the result. Signed operands need no absolute-value step and no final negation, because sign extension and the recoding carry the sign through the sum.

A client raises `in_valid` together with the operands. On the next clock edge, `product` holds their product and `out_valid` is high. A new operand pair may be presented every cycle.

Top module: `booth_tree_mul`

## Requirements
- R1: When `in_valid` is high at a rising clock edge, `product` after that edge equals the exact 32-bit two's-complement product of `mcand` and `mplier`, both read as signed.
- R2: `out_valid` equals the value `in_valid` had at the previous rising edge.
- R3: When `in_valid` is low at a rising edge, `product` keeps its previous value, whatever the operands are.
- R4: With `rst` high at a rising edge (synchronous, active high), `out_valid` and `product` become 0.
- R5: Digit k of the recoding is formed from multiplier bits 2k+1 and 2k, and from an incoming carry equal to bit 2k-1 (0 for k = 0). Taking (bit 2k+1, bit 2k, carry) as a 3-bit code, the digit values are: 000 gives 0, 001 gives +1, 010 gives +1, 011 gives +2, 100 gives -2, 101 gives -1, 110 gives -1, 111 gives 0. Digit k carries weight 4^k.
- R6: Each digit selects at most one magnitude, either 1x or 2x the multiplicand. A negation is applied only together with a nonzero magnitude.
- R7: The extreme operands 0, +1, -1, 32767 and -32768, in every pairing, give the exact product. This includes -32768 × -32768 = 0x40000000.
- R8: Operand pairs presented on consecutive cycles each produce their own product on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are valid and are to be multiplied |
| mcand | input | 16 | Multiplicand, two's complement |
| mplier | input | 16 | Multiplier, two's complement (the recoded operand) |
| out_valid | output | 1 | `product` was loaded on the last edge |
| product | output | 32 | Registered signed product |

## Verification
The bench builds the block at its default 16-bit operand width. At this width there are eight digits and nine reduction rows, so every corner pairing of the extreme values can be swept exhaustively. Several thousand random pairs then exercise every recoding code in every digit position. Multiplier patterns such as alternating bits and all-ones drive each digit through runs of the same code, which brings the carry between digits and the discarded top carry within reach. Stalled and back-to-back cycles cover the hold and valid timing.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

    typedef struct packed {
        logic neg;
        logic one;
        logic two;
    } booth_sel_t;

    function automatic int csa_levels(input int rows);
        int c;
        int l;
        c = rows;
        l = 0;
        while (c > 2) begin
            c = (c / 3) * 2 + (c % 3);
            l = l + 1;
        end
        return l;
    endfunction

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
    import booth_mul_pkg::*;
#(
    parameter int W = 16,
    localparam int NDIG = W / 2
) (
    input  logic [W-1:0]                mplier,
    output booth_sel_t [NDIG-1:0]       sel
);

    genvar k;
    generate
        for (k = 0; k < NDIG; k++) begin : g_dig
            logic hi, lo, cin;
            assign hi = mplier[2*k+1];
            assign lo = mplier[2*k];
            if (k == 0) begin : g_first
                assign cin = 1'b0;
            end else begin : g_rest
                assign cin = mplier[2*k-1];
            end
            assign sel[k].one = lo ^ cin;
            assign sel[k].two = (hi & ~lo & ~cin) | (~hi & lo & cin);
            assign sel[k].neg = hi & ~(lo & cin);
        end
    endgenerate

endmodule

// File: rtl/booth_pp_gen.sv
module booth_pp_gen
    import booth_mul_pkg::*;
#(
    parameter int W   = 16,
    parameter int IDX = 0,
    localparam int PW = 2 * W
) (
    input  logic [W-1:0]  mcand,
    input  booth_sel_t    sel,
    output logic [PW-1:0] pp
);

    logic [W:0]    mag;
    logic [W:0]    val;
    logic [PW-1:0] ext;

    always_comb begin
        if (sel.one)      mag = {mcand[W-1], mcand};
        else if (sel.two) mag = {mcand, 1'b0};
        else              mag = '0;
        val = sel.neg ? ~mag : mag;
        ext = {{(PW-W-1){val[W]}}, val};
        pp  = ext << (2 * IDX);
    end

endmodule

// File: rtl/csa_reduce.sv
module csa_reduce
    import booth_mul_pkg::*;
#(
    parameter int WD = 32,
    parameter int N  = 9,
    localparam int LEVELS = csa_levels(N)
) (
    input  logic [WD-1:0] rows [N],
    output logic [WD-1:0] out_a,
    output logic [WD-1:0] out_b
);

    logic [WD-1:0] work [N];
    logic [WD-1:0] nxt  [N];
    int cnt;
    int ncnt;

    always_comb begin
        work = rows;
        cnt  = N;
        for (int lv = 0; lv < LEVELS; lv++) begin
            for (int i = 0; i < N; i++) nxt[i] = '0;
            ncnt = 0;
            for (int g = 0; g < N; g += 3) begin
                if (g + 2 < cnt) begin
                    nxt[ncnt]     = work[g] ^ work[g+1] ^ work[g+2];
                    nxt[ncnt + 1] = ((work[g] & work[g+1]) | (work[g] & work[g+2])
                                   | (work[g+1] & work[g+2])) << 1;
                    ncnt = ncnt + 2;
                end else begin
                    for (int k = 0; k < 2; k++) begin
                        if (g + k < cnt) begin
                            nxt[ncnt] = work[g+k];
                            ncnt = ncnt + 1;
                        end
                    end
                end
            end
            work = nxt;
            cnt  = ncnt;
        end
        out_a = work[0];
        out_b = (N > 1) ? work[1] : '0;
    end

endmodule

// File: rtl/booth_tree_mul.sv
module booth_tree_mul
    import booth_mul_pkg::*;
#(
    parameter int W = 16,
    localparam int NDIG = W / 2,
    localparam int PW   = 2 * W,
    localparam int NROW = NDIG + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [W-1:0]  mcand,
    input  logic [W-1:0]  mplier,
    output logic          out_valid,
    output logic [PW-1:0] product
);

    typedef struct packed {
        logic          vld;
        logic [PW-1:0] prod;
    } state_t;

    state_t state_d, state_q;

    booth_sel_t [NDIG-1:0] sel_w;
    logic [PW-1:0] rows_w [NROW];
    logic [PW-1:0] corr_w;
    logic [PW-1:0] red_a_w, red_b_w;

    booth_recoder #(.W(W)) u_rec (
        .mplier (mplier),
        .sel    (sel_w)
    );

    genvar k;
    generate
        for (k = 0; k < NDIG; k++) begin : g_pp
            booth_pp_gen #(.W(W), .IDX(k)) u_pp (
                .mcand (mcand),
                .sel   (sel_w[k]),
                .pp    (rows_w[k])
            );
        end
    endgenerate

    always_comb begin
        corr_w = '0;
        for (int i = 0; i < NDIG; i++) corr_w[2*i] = sel_w[i].neg;
    end

    assign rows_w[NDIG] = corr_w;

    csa_reduce #(.WD(PW), .N(NROW)) u_tree (
        .rows  (rows_w),
        .out_a (red_a_w),
        .out_b (red_b_w)
    );

    always_comb begin
        state_d      = state_q;
        state_d.vld  = in_valid;
        if (in_valid) state_d.prod = red_a_w + red_b_w;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign out_valid = state_q.vld;
    assign product   = state_q.prod;

endmodule

// File: rtl/booth_tree_mul_chk.sv
module booth_tree_mul_chk
    import booth_mul_pkg::*;
#(
    parameter int W = 16,
    localparam int NDIG = W / 2,
    localparam int PW   = 2 * W
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  in_valid,
    input logic [W-1:0]          mcand,
    input logic [W-1:0]          mplier,
    input logic                  out_valid,
    input logic [PW-1:0]         product,
    input booth_sel_t [NDIG-1:0] sel
);

    logic signed [PW-1:0] ref_prod;
    assign ref_prod = PW'($signed(mcand)) * PW'($signed(mplier));

    assert_product_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> product == $past(ref_prod));

    assert_valid_rise_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_valid_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(product));

    assert_reset_clear_R4: assert property (@(posedge clk)
        rst |=> (!out_valid && product == '0));

    genvar k;
    generate
        for (k = 0; k < NDIG; k++) begin : g_dig
            assert_one_mag_R6: assert property (@(posedge clk) disable iff (rst)
                $onehot0({sel[k].one, sel[k].two}));
            assert_neg_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
                sel[k].neg |-> (sel[k].one || sel[k].two));
        end
    endgenerate

endmodule

bind booth_tree_mul booth_tree_mul_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .mcand     (mcand),
    .mplier    (mplier),
    .out_valid (out_valid),
    .product   (product),
    .sel       (sel_w)
);

// File: tb/booth_tree_mul_test.sv
module booth_tree_mul_test;

    localparam int W  = 16;
    localparam int PW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [W-1:0]  mcand, mplier;
    logic          out_valid;
    logic [PW-1:0] product;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    booth_tree_mul #(.W(W)) uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .mcand     (mcand),
        .mplier    (mplier),
        .out_valid (out_valid),
        .product   (product)
    );

    function automatic logic [PW-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
        longint sa, sb;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        return PW'(sa * sb);
    endfunction

    task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // present one pair, then check it at the next falling edge
    task automatic one_mul(input string req, input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        mcand    = a;
        mplier   = b;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, product, ref_mul(a, b));
        check({req, "_valid"}, PW'(out_valid), PW'(1));
    endtask

    logic [W-1:0] corners [5] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000};
    logic [W-1:0] pats    [6] = '{16'h5555, 16'hAAAA, 16'hFFFF, 16'h3333, 16'hCCCC, 16'h6DB6};

    initial begin
        rst = 1'b1; in_valid = 1'b0; mcand = '0; mplier = '0;
        repeat (3) @(negedge clk);
        // R4: reset state
        check("R4_prod", product, '0);
        check("R4_valid", PW'(out_valid), '0);
        rst = 1'b0;

        // R7: all corner pairings
        for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++)
                one_mul("R7", corners[i], corners[j]);
        one_mul("R7_minmin", 16'h8000, 16'h8000);
        check("R7_minmin_val", product, 32'h4000_0000);

        // R5: digit code runs across all positions
        for (int i = 0; i < 6; i++) begin
            one_mul("R5", 16'd12345, pats[i]);
            one_mul("R5", 16'hB1C7, pats[i]);
        end

        // R6: multiplier codes 111 and 000 mixed with 2x digits, extreme multiplicand
        one_mul("R6", 16'h8000, 16'h9C63);
        one_mul("R6", 16'h7FFF, 16'h6339);

        // R1: random pairs
        for (int n = 0; n < 10000; n++)
            one_mul("R1", W'($urandom), W'($urandom));

        // R3: stalled cycles with changing operands leave product alone
        one_mul("R3_setup", 16'h1234, 16'hFEDC);
        begin
            logic [PW-1:0] held;
            held = ref_mul(16'h1234, 16'hFEDC);
            for (int n = 0; n < 4; n++) begin
                @(negedge clk);
                in_valid = 1'b0;
                mcand    = W'($urandom);
                mplier   = W'($urandom);
                @(negedge clk);
                check("R3", product, held);
                check("R2_idle", PW'(out_valid), '0);
            end
        end

        // R8 / R2: back-to-back operands every cycle
        begin
            logic [W-1:0] pa, pb;
            @(negedge clk);
            pa = 16'h0F0F; pb = 16'hF00F;
            in_valid = 1'b1; mcand = pa; mplier = pb;
            for (int n = 0; n < 50; n++) begin
                logic [W-1:0] na, nb;
                na = W'($urandom); nb = W'($urandom);
                @(negedge clk);
                check("R8", product, ref_mul(pa, pb));
                check("R2_stream", PW'(out_valid), PW'(1));
                mcand = na; mplier = nb; pa = na; pb = nb;
            end
            @(negedge clk);
            in_valid = 1'b0;
            check("R8_last", product, ref_mul(pa, pb));
            @(negedge clk);
            check("R2_drop", PW'(out_valid), '0);
        end

        // R4: reset mid-run clears the output
        one_mul("R4_pre", 16'h7FFF, 16'h7FFF);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R4_mid_prod", product, '0);
        check("R4_mid_valid", PW'(out_valid), '0);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule